// File: doc/BRIEF.md
# Memory-Mapped Parallel Display Write Bridge

This block is a bus agent that sits between a fast on-chip host and an external display controller with an 8080-style parallel write port. The host sees two writable word locations. A write to the first sends a command byte or word to the display. A write to the second sends a parameter or a pixel value. Either write produces one complete, slow write cycle on a 16-bit parallel bus. The block stalls the host with a wait request until that cycle has finished.

Each external write cycle has three timed phases. In the setup phase, chip select goes low while the write strobe stays high, so data and the data/command line settle. In the strobe phase, the write strobe is held low. In the hold phase, the strobe is high again and the data is unchanged, because the display captures the data on the rising strobe edge. The length of each phase is an elaboration parameter, counted in system clock cycles. One reloaded down-counter times all three phases. The block never reads from the display, and it accepts only one transfer at a time.

Top module: `lcd_wr_bridge`

## Requirements
- R1: After reset, lcd_cs_n, lcd_wr_n, lcd_rd_n and lcd_dc are 1, lcd_d is 0 and bus_waitreq is 0.
- R2: A write to word offset 0 starts a transfer that drives lcd_dc = 0 and lcd_d = the written value while lcd_cs_n is low.
- R3: A write to word offset 1 starts a transfer that drives lcd_dc = 1 and lcd_d = the written value while lcd_cs_n is low.
- R4: In the cycle after the write arrives, lcd_cs_n goes low. For exactly SETUP_CYC cycles it stays low with lcd_wr_n high before lcd_wr_n falls.
- R5: lcd_wr_n stays low for exactly PULSE_CYC consecutive cycles per transfer and is never low while lcd_cs_n is high.
- R6: After lcd_wr_n rises, lcd_cs_n stays low with lcd_wr_n high for exactly HOLD_CYC cycles and then returns high.
- R7: bus_waitreq is 1 from the arrival cycle of an accepted write for 1+SETUP_CYC+PULSE_CYC+HOLD_CYC cycles. It is 0 in the following cycle, which is the cycle in which lcd_cs_n returns high. Each transfer therefore produces exactly one strobe.
- R8: lcd_d and lcd_dc do not change while lcd_cs_n stays low.
- R9: Reads complete without stalling (bus_waitreq = 0), return bus_rdata = 0, and cause no activity on the display bus.
- R10: Writes to word offsets 2 and 3 complete without stalling and start no transfer: lcd_cs_n stays high.
- R11: lcd_rd_n is 1 at all times.
- R12: A write presented in the cycle right after a finish cycle is accepted at once. Its setup phase begins on the next cycle, with no extra gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset of the host transfer |
| bus_read | input | 1 | Host read request |
| bus_write | input | 1 | Host write request |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Read data (always zero) |
| bus_waitreq | output | 1 | Stalls the host while a display cycle runs |
| lcd_cs_n | output | 1 | Display chip select, active low |
| lcd_wr_n | output | 1 | Display write strobe, data captured on rising edge |
| lcd_rd_n | output | 1 | Display read strobe, held inactive |
| lcd_dc | output | 1 | 0 = command, 1 = parameter/pixel data |
| lcd_d | output | DATA_W | Display parallel data bus |

## Verification
Let k be the cycle in which a write arrives, counted with k = 0. bus_waitreq answers combinationally in that same cycle. All display pins come from registers, so lcd_cs_n first falls at k = 1. lcd_wr_n is low from k = 1+SETUP_CYC up to and including k = SETUP_CYC+PULSE_CYC. The finish cycle, with chip select high and the wait request dropped, is k = 1+SETUP_CYC+PULSE_CYC+HOLD_CYC. The bench drives each input on the falling clock edge and samples one time unit later. It compares every cycle of each transfer against a phase table computed from k. Ignored writes and reads are checked in their own cycle for the wait request and read data, and again one cycle later for chip select.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_FINISH = 3'd4
  } wr_state_t;
endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R5: once reloaded, the counter reaches zero by counting down one per cycle
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lcd_wr_fsm.sv
module lcd_wr_fsm
  import lcd_wr_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output wr_state_t        state
);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  wr_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = SETUP_LD;
      end
      ST_SETUP: if (tmr_zero) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = PULSE_LD;
      end
      ST_STROBE: if (tmr_zero) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = HOLD_LD;
      end
      ST_HOLD:   if (tmr_zero) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R12: a setup phase is only ever entered straight from idle
  p_setup_from_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && $past(state_q) != ST_SETUP) |-> $past(state_q) == ST_IDLE);
  // R7: finish lasts a single cycle
  p_finish_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FINISH) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/lcd_wr_latch.sv
module lcd_wr_latch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              dc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              dc_out,
  output logic [DATA_W-1:0] data_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_out   <= 1'b1;
      data_out <= '0;
    end else if (capture) begin
      dc_out   <= dc_in;
      data_out <= data_in;
    end
  end
endmodule

// File: rtl/lcd_wr_bridge.sv
module lcd_wr_bridge
  import lcd_wr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 2,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_read,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_waitreq,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic              lcd_dc,
  output logic [DATA_W-1:0] lcd_d
);
  localparam int MAX_CYC = (SETUP_CYC > PULSE_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  wr_state_t        state;
  logic             addr_ok, start, tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;

  assign addr_ok = (bus_addr < ADDR_W'(2));
  assign start   = bus_write && addr_ok && (state == ST_IDLE);

  lcd_wr_fsm #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC),   .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .state(state)
  );

  lcd_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  lcd_wr_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .capture(start), .dc_in(bus_addr[0]),
    .data_in(bus_wdata), .dc_out(lcd_dc), .data_out(lcd_d)
  );

  assign lcd_cs_n    = (state == ST_IDLE) || (state == ST_FINISH);
  assign lcd_wr_n    = (state != ST_STROBE);
  assign lcd_rd_n    = 1'b1;
  assign bus_rdata   = '0;
  assign bus_waitreq = bus_write && addr_ok && (state != ST_FINISH);

  // R8: data and select line frozen while the display is selected
  p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && !$past(lcd_cs_n)) |-> ($stable(lcd_d) && $stable(lcd_dc)));
  // R5: strobe only inside chip select
  p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n);
  // R4: strobe falls only after a cycle of chip select with strobe high
  p_setup_before_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_wr_n) |-> ($past(!lcd_cs_n) && $past(lcd_wr_n)));
  // R7: host is released in the cycle chip select rises
  p_release_at_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cs_n) |-> !bus_waitreq);
  // R9: a lone read never stalls
  p_read_nostall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && !bus_write) |-> !bus_waitreq);
endmodule

// File: tb/sim_lcd_wr_bridge.sv
module sim_lcd_wr_bridge;
  localparam int DW = 16;
  localparam int S  = 2;
  localparam int P  = 3;
  localparam int H  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    bus_addr;
  logic          bus_read, bus_write;
  logic [DW-1:0] bus_wdata, bus_rdata, lcd_d;
  logic          bus_waitreq, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dc;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  lcd_wr_bridge #(.DATA_W(DW), .ADDR_W(2), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_waitreq(bus_waitreq), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
    .lcd_rd_n(lcd_rd_n), .lcd_dc(lcd_dc), .lcd_d(lcd_d)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected {cs_n, wr_n, waitreq} at cycle k of a transfer (k=0 arrival)
  function automatic logic [2:0] exp_phase(input int k);
    if (k == 0)               return 3'b111;
    else if (k <= S)          return 3'b011;
    else if (k <= S + P)      return 3'b001;
    else if (k <= S + P + H)  return 3'b011;
    else                      return 3'b110;
  endfunction

  task automatic next_cycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d);
    logic [2:0] e;
    bus_addr = a; bus_wdata = d; bus_write = 1'b1; bus_read = 1'b0;
    if (a >= 2) begin
      #1;
      chk(bus_waitreq == 1'b0, "R10 waitreq", bus_waitreq, 0);
      next_cycle();
      bus_write = 1'b0;
      #1;
      chk(lcd_cs_n == 1'b1, "R10 cs_n", lcd_cs_n, 1);
      return;
    end
    for (int k = 0; k <= S + P + H + 1; k++) begin
      #1;
      e = exp_phase(k);
      chk({lcd_cs_n, lcd_wr_n, bus_waitreq} == e, "R4/R5/R6/R7 phase", {lcd_cs_n, lcd_wr_n, bus_waitreq}, e);
      chk(lcd_rd_n == 1'b1, "R11 rd_n", lcd_rd_n, 1);
      if (!lcd_cs_n) begin
        chk(lcd_d == d, "R2/R3/R8 data", lcd_d, d);
        chk(lcd_dc == a[0], a[0] ? "R3 dc" : "R2 dc", lcd_dc, a[0]);
      end
      next_cycle();
    end
    bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a);
    bus_addr = a; bus_read = 1'b1; bus_write = 1'b0;
    #1;
    chk(bus_waitreq == 1'b0, "R9 waitreq", bus_waitreq, 0);
    chk(bus_rdata == '0, "R9 rdata", bus_rdata, 0);
    next_cycle();
    bus_read = 1'b0;
    #1;
    chk(lcd_cs_n == 1'b1, "R9 cs_n", lcd_cs_n, 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [1:0] a;
    seed = 32'h1A2B;
    void'($urandom(seed));
    rst_n = 1'b0; bus_addr = '0; bus_read = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk({lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dc} == 4'hF, "R1 pins", {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dc}, 4'hF);
    chk(lcd_d == '0, "R1 data", lcd_d, 0);
    chk(bus_waitreq == 1'b0, "R1 waitreq", bus_waitreq, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    // directed corners
    do_write(2'd0, 16'h002C);   // R2 command
    do_write(2'd1, 16'hFFFF);   // R3 data, R12 back-to-back
    do_write(2'd1, 16'h0000);   // R12 back-to-back
    do_read(2'd0);              // R9
    do_write(2'd2, 16'hBEEF);   // R10
    do_write(2'd3, 16'h1234);   // R10
    chk(lcd_d == 16'h0000, "R10 data untouched", lcd_d, 0);
    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      a = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) do_read(a);
      else do_write(a, 16'($urandom));
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) next_cycle();
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule